// File: doc/BRIEF.md
# Addressable Tap Shift Register

The block is a serial delay line of 1-bit stages whose read point is chosen at run time. Each enabled rising clock edge moves every stored bit one stage deeper and loads a fresh serial bit into the first stage. A tap address picks which stage drives the data output. Because that choice is purely combinational, the effective delay changes as soon as the address changes. The stored history stays in place, so nothing is reloaded or flushed.

Storage is built from segments of `SEG_DEPTH` stages (default 16), each with its own 16-to-1 tap multiplexer. `NUM_SEGS` (1 to 4, default 4) segments are chained end to end, which gives a line of up to 64 stages with a 6-bit address. The low address bits pick the stage inside a segment and the high bits pick the segment. A separate chain output always shows the deepest stage, so a further line can be appended without using the tap multiplexer. The storage has no reset, and its contents are undefined until enough enabled edges have passed to fill it.

Top module: `atsr_top`

## Requirements
- R1: On a rising clock edge with `shift_en` high, stage 0 loads `ser_in` and every stage k loads the old value of stage k-1.
- R2: On a rising clock edge with `shift_en` low, every stage keeps its value, whatever `ser_in` does.
- R3: `tap_out` equals stage `tap_addr`. A bit loaded on an enabled edge therefore appears at address a after a+1 enabled edges.
- R4: `tap_out` follows a change of `tap_addr` within the same clock cycle, with no clock edge needed.
- R5: `chain_out` always equals the deepest stage (stage `SEG_DEPTH*NUM_SEGS-1`, which is 63 by default), whatever value `tap_addr` has.
- R6: With more than one segment, `tap_addr[ADDR_W-1:log2(SEG_DEPTH)]` selects the segment and the low bits select the stage inside it. The last stage of segment i feeds the first stage of segment i+1, so addresses 15 and 16 are adjacent stages.
- R7: With the default parameters the line is 64 stages long and `tap_addr` is 6 bits wide, so address 63 gives a delay of 64 enabled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| shift_en | input | 1 | Shift enable; low holds every stage |
| ser_in | input | 1 | Serial data into stage 0 |
| tap_addr | input | ADDR_W (6) | Stage chosen to drive `tap_out` |
| tap_out | output | 1 | Value of the addressed stage (combinational in `tap_addr`) |
| chain_out | output | 1 | Value of the deepest stage, for appending another line |

## Verification
Stored data moves exactly one stage per enabled edge. A bit driven on `ser_in` during the low clock phase is therefore due at address a only after a+1 enabled edges. The bench's reference history is advanced only at those edges, and outputs are sampled in the low phase after the edge. A change of the address is due in the same cycle, so several addresses are checked one after another inside a single low phase with no edge between them. For held cycles the expected value is the unchanged history, read back across all 64 addresses.

// File: rtl/atsr_pkg.sv
`timescale 1ns/1ps
package atsr_pkg;
    localparam int unsigned SEG_DEPTH_DFLT = 16;
    localparam int unsigned MAX_SEGS       = 4;

    // Select width for an n-way choice; a single choice still needs one bit.
    function automatic int unsigned sel_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/atsr_mux.sv
`timescale 1ns/1ps
module atsr_mux #(
    parameter int unsigned N = 16,
    localparam int unsigned SEL_W = atsr_pkg::sel_width(N)
) (
    input  logic [N-1:0]     d,
    input  logic [SEL_W-1:0] sel,
    output logic             y
);
    // An out-of-range select (N not a power of two) yields 0.
    always_comb begin
        y = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            if (sel == SEL_W'(i)) y = d[i];
        end
    end
endmodule

// File: rtl/atsr_segment.sv
`timescale 1ns/1ps
module atsr_segment #(
    parameter int unsigned DEPTH = atsr_pkg::SEG_DEPTH_DFLT,
    localparam int unsigned SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             seg_in,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             tap_o,
    output logic             last_o
);
    typedef struct packed {
        logic [DEPTH-1:0] stg;
    } seg_state_t;

    seg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) st_d.stg = {st_q.stg[DEPTH-2:0], seg_in};
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    atsr_mux #(.N(DEPTH)) u_tap_mux (
        .d   (st_q.stg),
        .sel (tap_sel),
        .y   (tap_o)
    );

    assign last_o = st_q.stg[DEPTH-1];

    // Checks are armed after the first edge so $past always has history.
    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= 1'b1;

    p_head_load_r1: assert property (@(posedge clk) disable iff (!armed_q)
        shift_en |=> st_q.stg[0] == $past(seg_in));

    for (genvar k = 1; k < int'(DEPTH); k++) begin : g_chk
        p_stage_move_r1: assert property (@(posedge clk) disable iff (!armed_q)
            shift_en |=> st_q.stg[k] == $past(st_q.stg[k-1]));
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!armed_q)
        !shift_en |=> $stable(st_q.stg));
endmodule

// File: rtl/atsr_top.sv
`timescale 1ns/1ps
module atsr_top #(
    parameter int unsigned SEG_DEPTH = atsr_pkg::SEG_DEPTH_DFLT,
    parameter int unsigned NUM_SEGS  = atsr_pkg::MAX_SEGS,
    localparam int unsigned LOC_W  = $clog2(SEG_DEPTH),
    localparam int unsigned SEGS_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 0,
    localparam int unsigned ADDR_W = LOC_W + SEGS_W
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic              ser_in,
    input  logic [ADDR_W-1:0] tap_addr,
    output logic              tap_out,
    output logic              chain_out
);
    logic [NUM_SEGS-1:0] seg_in;
    logic [NUM_SEGS-1:0] seg_tap;
    logic [NUM_SEGS-1:0] seg_last;

    assign seg_in[0] = ser_in;

    for (genvar i = 0; i < int'(NUM_SEGS); i++) begin : gen_seg
        if (i > 0) begin : g_link
            assign seg_in[i] = seg_last[i-1];
        end
        atsr_segment #(.DEPTH(SEG_DEPTH)) u_seg (
            .clk      (clk),
            .shift_en (shift_en),
            .seg_in   (seg_in[i]),
            .tap_sel  (tap_addr[LOC_W-1:0]),
            .tap_o    (seg_tap[i]),
            .last_o   (seg_last[i])
        );
    end

    if (NUM_SEGS > 1) begin : g_segsel
        atsr_mux #(.N(NUM_SEGS)) u_seg_mux (
            .d   (seg_tap),
            .sel (tap_addr[ADDR_W-1:LOC_W]),
            .y   (tap_out)
        );
    end else begin : g_single
        assign tap_out = seg_tap[0];
    end

    assign chain_out = seg_last[NUM_SEGS-1];

    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= 1'b1;

    // Deepest address reaches the same stage as the chain output.
    p_chain_tap_r5: assert property (@(posedge clk) disable iff (!armed_q)
        (tap_addr == '1) |-> (tap_out == chain_out));

    // With no shift and a steady address the tap cannot move.
    p_addr_only_r4: assert property (@(posedge clk) disable iff (!armed_q)
        ($past(!shift_en) && $stable(tap_addr)) |-> $stable(tap_out));

    for (genvar i = 1; i < int'(NUM_SEGS); i++) begin : g_seam_chk
        p_seam_r6: assert property (@(posedge clk) disable iff (!armed_q)
            shift_en |=> gen_seg[i].u_seg.st_q.stg[0] == $past(seg_last[i-1]));
    end
endmodule

// File: tb/atsr_top_bench.sv
`timescale 1ns/1ps
module atsr_top_bench;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned NSEG  = 4;
    localparam int unsigned LEN   = DEPTH * NSEG;
    localparam int unsigned AW    = 6;

    logic          clk = 1'b0;
    logic          shift_en = 1'b0;
    logic          ser_in = 1'b0;
    logic [AW-1:0] tap_addr = '0;
    logic          tap_out, chain_out;

    always #2 clk = ~clk; // 250 MHz

    atsr_top #(.SEG_DEPTH(DEPTH), .NUM_SEGS(NSEG)) u_atsr_top (
        .clk(clk), .shift_en(shift_en), .ser_in(ser_in),
        .tap_addr(tap_addr), .tap_out(tap_out), .chain_out(chain_out)
    );

    typedef struct {
        bit    exp;
        bit    is_chain;
        int    addr;
        string req;
    } item_t;

    item_t    exp_q[$];
    bit [LEN-1:0] hist = '0;
    int       n_chk = 0;
    int       n_fail = 0;
    bit       done = 0;
    event     mon_ev;

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            @(mon_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                bit act;
                it = exp_q.pop_front();
                act = it.is_chain ? chain_out : tap_out;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: %s addr %0d got %0b expected %0b",
                             it.req, it.is_chain ? "chain_out" : "tap_out",
                             it.addr, act, it.exp);
                end
            end
        end
    end

    // One clock: drive in low phase, update model at the edge, return in next low phase.
    task automatic step(input bit d, input bit e);
        ser_in = d;
        shift_en = e;
        @(posedge clk);
        if (e) hist = {hist[LEN-2:0], d};
        @(negedge clk);
        #0.1;
    endtask

    task automatic chk_tap(input int a, input string req);
        item_t it;
        tap_addr = AW'(a);
        #0.1;
        it.exp = hist[a]; it.is_chain = 1'b0; it.addr = a; it.req = req;
        exp_q.push_back(it);
        ->mon_ev;
        #0.2;
    endtask

    task automatic chk_chain(input string req);
        item_t it;
        #0.05;
        it.exp = hist[LEN-1]; it.is_chain = 1'b1; it.addr = int'(tap_addr); it.req = req;
        exp_q.push_back(it);
        ->mon_ev;
        #0.1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        #0.1;
        // Fill with zeros to give a known starting state.
        for (int i = 0; i < int'(LEN); i++) step(1'b0, 1'b1);
        chk_tap(0, "R3"); chk_tap(31, "R3"); chk_tap(63, "R7");
        chk_chain("R5");

        // R1: one enabled edge loads stage 0 only.
        step(1'b1, 1'b1);
        chk_tap(0, "R1"); chk_tap(1, "R1"); chk_chain("R5");
        step(1'b0, 1'b1);
        chk_tap(1, "R1"); chk_tap(0, "R1");

        // R3/R5: random stream, walking the tap address.
        for (int i = 0; i < 96; i++) begin
            step(1'($urandom), 1'b1);
            chk_tap(i % int'(LEN), "R3");
            chk_chain("R5");
        end

        // R6: segment seams, addresses on both sides.
        chk_tap(15, "R6"); chk_tap(16, "R6"); chk_tap(31, "R6"); chk_tap(32, "R6");
        step(1'b0, 1'b0);
        chk_tap(47, "R6"); chk_tap(48, "R6"); chk_tap(63, "R6"); chk_chain("R5");

        // R4: address changes inside one low phase, no edge between.
        step(1'b1, 1'b1);
        chk_tap(5, "R4"); chk_tap(40, "R4"); chk_tap(5, "R4"); chk_tap(22, "R4");

        // R2: held edges with a toggling input, then read all addresses.
        for (int i = 0; i < 12; i++) step(1'(i), 1'b0);
        for (int b = 0; b < int'(LEN); b += 4) begin
            for (int a = b; a < b + 4; a++) chk_tap(a, "R2");
            chk_chain("R2");
            step(1'(~b), 1'b0);
        end

        // R3/R7: single-one impulse, delay equals address plus one.
        foreach (hist[j]) begin end
        for (int s = 0; s < 4; s++) begin
            int a;
            a = (s == 0) ? 0 : (s == 1) ? 15 : (s == 2) ? 16 : 63;
            for (int i = 0; i < int'(LEN); i++) step(1'b0, 1'b1);
            step(1'b1, 1'b1);
            for (int i = 0; i < a; i++) begin
                chk_tap(a, (a == 63) ? "R7" : "R3");
                step(1'b0, 1'b1);
            end
            chk_tap(a, (a == 63) ? "R7" : "R3");
            if (a == 63) chk_chain("R5");
        end

        done = 1;
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule